// File: doc/BRIEF.md
# Polled Port Status Scheduler

This block sits on the sending side of a multi-port packet link. Every cycle it puts a port number on a poll address output. The receiving side answers on a single shared status line, a fixed number of cycles later, with one bit that says whether that port can take one more payload burst. The block keeps one ready flag per port, loaded from those answers.

An arbiter picks which port to serve. A port is eligible when its ready flag is set and the local queue shows data for it. A grant spends the ready flag. The same port cannot be chosen again until a later poll of that port comes back ready.

The poll order is either a plain rotation over all ports or a programmable sequence held in a small table. The table lets fast ports be polled more often than slow ones. It can only be rewritten while the block is in rotation mode.

Top module: `poll_sched`

## Requirements
- R1: While `wt_mode` is low, `poll_addr` is 0 in the first cycle after reset and rises by one every cycle, wrapping from NPORT-1 to 0.
- R2: While `wt_mode` is high, `poll_addr` shows table entry 0 in the first cycle of the mode, then entries 1, 2 and so on. After entry `tbl_len`-1 it wraps back to entry 0. When `wt_mode` falls, the rotation of R1 restarts at port 0.
- R3: The `sts_in` value seen in the cycle that comes SMP_LAT cycles after port P was driven on `poll_addr` becomes the ready flag of port P. A value of 1 means ready and a value of 0 means not ready.
- R4: A grant clears the ready flag of the granted port at the end of the grant cycle. That port is not granted again until a later status sample of 1 for it. If a sample for that port lands in the grant cycle itself, the sample decides the flag.
- R5: `gnt_valid` is high only for a port whose ready flag is set and whose `data_avail` bit is high.
- R6: The granted port is the first eligible port found by counting upward from the last granted port, wrapping past NPORT-1. After reset the search starts at port 0.
- R7: `gnt_valid` is a one-cycle strobe. Two grants are always at least BURST_LEN cycles apart. A grant is issued in any cycle that has no burst in progress and at least one eligible port.
- R8: A table write (`wt_we` high, entry `wt_addr`, value `wt_data`) takes effect only while `wt_mode` is low. A write made while `wt_mode` is high leaves the table unchanged.
- R9: During reset, `gnt_valid` is low, every ready flag is clear, every table entry is 0 and `poll_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | High selects the table-driven poll order |
| wt_we | input | 1 | Table write enable |
| wt_addr | input | $clog2(WDEPTH) | Table entry to write |
| wt_data | input | $clog2(NPORT) | Port number stored in the entry |
| tbl_len | input | $clog2(WDEPTH)+1 | Number of table entries used in table mode (1..WDEPTH) |
| poll_addr | output | $clog2(NPORT) | Port being polled this cycle |
| sts_in | input | 1 | Shared status bit returned by the receiver |
| data_avail | input | NPORT | Per-port local data waiting |
| gnt_valid | output | 1 | Burst-start strobe |
| gnt_port | output | $clog2(NPORT) | Port granted, valid with `gnt_valid` |

## Verification
The bench drives a receiver model that answers from its own ready map with the poll delay applied. It runs a reference of the poll order, the ready flags and the arbiter in lock step with the design, and compares every cycle in both poll modes.

The cases it targets are these:
- A status sample and a grant for the same port in the same cycle. A design that lets the grant win would drop a fresh credit and stall that port.
- A port that is granted and then polled not-ready. A design that does not spend the flag would issue a second burst without permission.
- Grants that must skip ports without data.
- A table write attempted in table mode. A design that accepts it would change the poll order at once.

// File: rtl/poll_sched_pkg.sv
package poll_sched_pkg;

  // Next value of a counter that runs 0..lim-1; a limit of 0 behaves as 1.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/poll_seq.sv
module poll_seq
  import poll_sched_pkg::*;
#(
  parameter int NPORT  = 8,
  parameter int WDEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wt_mode,
  input  logic                       wt_we,
  input  logic [$clog2(WDEPTH)-1:0]  wt_addr,
  input  logic [$clog2(NPORT)-1:0]   wt_data,
  input  logic [$clog2(WDEPTH):0]    tbl_len,
  output logic [$clog2(NPORT)-1:0]   poll_addr
);
  localparam int PW  = $clog2(NPORT);
  localparam int WAW = $clog2(WDEPTH);

  logic [PW-1:0]  seq_tbl [WDEPTH];
  logic [PW-1:0]  rr_q;
  logic [WAW-1:0] idx_q;
  logic           tbl_wr_ok;

  assign tbl_wr_ok = wt_we && !wt_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q  <= '0;
      idx_q <= '0;
      for (int e = 0; e < WDEPTH; e++) seq_tbl[e] <= '0;
    end else begin
      if (tbl_wr_ok) seq_tbl[wt_addr] <= wt_data;
      rr_q  <= wt_mode  ? '0 : PW'(wrap_inc(32'(rr_q), NPORT));
      idx_q <= !wt_mode ? '0 : WAW'(wrap_inc(32'(idx_q), 32'(tbl_len)));
    end
  end

  assign poll_addr = wt_mode ? seq_tbl[idx_q] : rr_q;

  // A write attempted in table mode must not disturb the entry.
  AST_TBL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_we && wt_mode) |=> seq_tbl[$past(wt_addr)] == $past(seq_tbl[wt_addr])); // R8

endmodule

// File: rtl/rdy_track.sv
module rdy_track #(
  parameter int NPORT   = 8,
  parameter int SMP_LAT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NPORT)-1:0]  poll_addr,
  input  logic                      sts_in,
  input  logic                      clr_vld,
  input  logic [$clog2(NPORT)-1:0]  clr_port,
  output logic [NPORT-1:0]          rdy_q,
  output logic                      smp_hit,
  output logic [$clog2(NPORT)-1:0]  smp_port
);
  localparam int PW = $clog2(NPORT);

  logic [PW-1:0]      pa_q [SMP_LAT];
  logic [SMP_LAT-1:0] pv_q;

  // Delay line that aligns each polled address with its returning status bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= '0;
      for (int s = 0; s < SMP_LAT; s++) pa_q[s] <= '0;
    end else begin
      pv_q[0] <= 1'b1;
      pa_q[0] <= poll_addr;
      for (int s = 1; s < SMP_LAT; s++) begin
        pv_q[s] <= pv_q[s-1];
        pa_q[s] <= pa_q[s-1];
      end
    end
  end

  assign smp_hit  = pv_q[SMP_LAT-1];
  assign smp_port = pa_q[SMP_LAT-1];

  // Ready flags: a grant spends the flag; a sample in the same cycle wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (smp_hit && smp_port == PW'(p))      rdy_q[p] <= sts_in;
        else if (clr_vld && clr_port == PW'(p)) rdy_q[p] <= 1'b0;
      end
    end
  end

  AST_SAMPLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_hit |=> rdy_q[$past(smp_port)] == $past(sts_in)); // R3

  AST_GRANT_SPENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !(smp_hit && smp_port == clr_port)) |=> !rdy_q[$past(clr_port)]); // R4

endmodule

// File: rtl/grant_arb.sv
module grant_arb #(
  parameter int NPORT     = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          rdy,
  input  logic [NPORT-1:0]          avail,
  output logic                      gnt_valid,
  output logic [$clog2(NPORT)-1:0]  gnt_port
);
  localparam int PW = $clog2(NPORT);
  localparam int CW = $clog2(BURST_LEN + 1);

  logic [CW-1:0]    cnt_q;
  logic [PW-1:0]    ptr_q;
  logic [NPORT-1:0] elig;

  // Scan offsets from far to near so the nearest eligible port after 'last' wins.
  function automatic logic [PW-1:0] rot_pick(input logic [NPORT-1:0] e,
                                             input logic [PW-1:0]    last);
    logic [PW-1:0] r;
    int            k;
    r = last;
    for (int off = NPORT; off >= 1; off--) begin
      k = (int'(last) + off) % NPORT;
      if (e[k]) r = PW'(k);
    end
    return r;
  endfunction

  assign elig      = rdy & avail;
  assign gnt_valid = (cnt_q == '0) && (|elig);
  assign gnt_port  = rot_pick(elig, ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= PW'(NPORT - 1);
    end else if (gnt_valid) begin
      cnt_q <= CW'(BURST_LEN - 1);
      ptr_q <= gnt_port;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (rdy[gnt_port] && avail[gnt_port])); // R5

  generate
    if (BURST_LEN > 1) begin : g_gap
      AST_GNT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid); // R7
    end
  endgenerate

endmodule

// File: rtl/poll_sched.sv
module poll_sched #(
  parameter int NPORT     = 8,
  parameter int WDEPTH    = 8,
  parameter int SMP_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wt_mode,
  input  logic                       wt_we,
  input  logic [$clog2(WDEPTH)-1:0]  wt_addr,
  input  logic [$clog2(NPORT)-1:0]   wt_data,
  input  logic [$clog2(WDEPTH):0]    tbl_len,
  output logic [$clog2(NPORT)-1:0]   poll_addr,
  input  logic                       sts_in,
  input  logic [NPORT-1:0]           data_avail,
  output logic                       gnt_valid,
  output logic [$clog2(NPORT)-1:0]   gnt_port
);
  localparam int PW = $clog2(NPORT);

  logic [NPORT-1:0] rdy_vec;
  logic             smp_hit;
  logic [PW-1:0]    smp_port;

  poll_seq #(.NPORT(NPORT), .WDEPTH(WDEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .wt_we(wt_we),
    .wt_addr(wt_addr), .wt_data(wt_data), .tbl_len(tbl_len),
    .poll_addr(poll_addr)
  );

  rdy_track #(.NPORT(NPORT), .SMP_LAT(SMP_LAT)) u_rdy (
    .clk(clk), .rst_n(rst_n), .poll_addr(poll_addr), .sts_in(sts_in),
    .clr_vld(gnt_valid), .clr_port(gnt_port), .rdy_q(rdy_vec),
    .smp_hit(smp_hit), .smp_port(smp_port)
  );

  grant_arb #(.NPORT(NPORT), .BURST_LEN(BURST_LEN)) u_arb (
    .clk(clk), .rst_n(rst_n), .rdy(rdy_vec), .avail(data_avail),
    .gnt_valid(gnt_valid), .gnt_port(gnt_port)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!gnt_valid || rst_n)); // R9

endmodule

// File: tb/sim_poll_sched.sv
module sim_poll_sched;
  localparam int N   = 4;
  localparam int WD  = 4;
  localparam int LAT = 2;
  localparam int BL  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wt_mode = 1'b0, wt_we = 1'b0;
  logic [1:0] wt_addr = '0, wt_data = '0;
  logic [2:0] tbl_len = 3'd1;
  logic [1:0] poll_addr, gnt_port;
  logic       sts_in = 1'b0, gnt_valid;
  logic [N-1:0] data_avail = '0;

  poll_sched #(.NPORT(N), .WDEPTH(WD), .SMP_LAT(LAT), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .wt_we(wt_we),
    .wt_addr(wt_addr), .wt_data(wt_data), .tbl_len(tbl_len),
    .poll_addr(poll_addr), .sts_in(sts_in), .data_avail(data_avail),
    .gnt_valid(gnt_valid), .gnt_port(gnt_port)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc_no = 0, last_gnt = -1000;
  // reference state
  int m_rr = 0, m_idx = 0, m_cnt = 0, m_ptr = N - 1;
  int m_tbl [WD];
  int m_rdy [N];
  int m_ha  [LAT];
  int m_hv  [LAT];
  logic [N-1:0] sink = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc_no, act, exp);
    end
  endtask

  // One cycle, entered and left at a falling edge.
  task automatic cyc();
    int m_addr, gv, gp, s;
    sts_in = m_hv[LAT-1] ? sink[m_ha[LAT-1]] : 1'b0;   // R3 receiver answer
    #1;
    m_addr = wt_mode ? m_tbl[m_idx] : m_rr;
    gv = 0; gp = 0;
    if (m_cnt == 0)
      for (int off = 1; off <= N && !gv; off++) begin
        s = (m_ptr + off) % N;
        if (m_rdy[s] && data_avail[s]) begin gv = 1; gp = s; end
      end
    if (wt_mode) chk("R2 R8 poll order", poll_addr, m_addr);
    else         chk("R1 poll order", poll_addr, m_addr);
    chk("R3 R4 R5 R7 grant strobe", gnt_valid, gv);
    if (gv) chk("R6 granted port", gnt_port, gp);
    if (gnt_valid) begin
      chk("R4 R5 grant needs credit and data", m_rdy[gnt_port] && data_avail[gnt_port], 1);
      chk("R7 burst spacing", (cyc_no - last_gnt) >= BL, 1);
      last_gnt = cyc_no;
    end
    // advance reference to the next edge
    if (gv) begin m_rdy[gp] = 0; m_cnt = BL - 1; m_ptr = gp; end
    else if (m_cnt > 0) m_cnt--;
    if (m_hv[LAT-1]) m_rdy[m_ha[LAT-1]] = sink[m_ha[LAT-1]];
    for (int k = LAT - 1; k > 0; k--) begin m_ha[k] = m_ha[k-1]; m_hv[k] = m_hv[k-1]; end
    m_ha[0] = m_addr; m_hv[0] = 1;
    if (wt_we && !wt_mode) m_tbl[wt_addr] = wt_data;
    m_idx = wt_mode ? ((m_idx + 1 >= tbl_len) ? 0 : m_idx + 1) : 0;
    m_rr  = wt_mode ? 0 : (m_rr + 1) % N;
    cyc_no++;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int e = 0; e < WD; e++) m_tbl[e] = 0;
    for (int p = 0; p < N; p++) m_rdy[p] = 0;
    for (int k = 0; k < LAT; k++) begin m_ha[k] = 0; m_hv[k] = 0; end
    sink = '1; data_avail = '1;
    repeat (3) @(negedge clk);
    chk("R9 reset grant", gnt_valid, 0);
    chk("R9 reset poll", poll_addr, 0);
    rst_n = 1'b1;
    // rotation mode, shifting credit and data patterns
    for (int i = 0; i < 600; i++) begin
      sink       = 4'((i / 7) * 5 + 3);
      data_avail = (i < 150) ? 4'hF : 4'((i / 5) * 3 + 1);
      cyc();
    end
    // load the table in rotation mode: 2,1,2,3
    for (int e = 0; e < WD; e++) begin
      wt_we = 1'b1; wt_addr = 2'(e); wt_data = 2'((e == 1) ? 1 : (e == 3 ? 3 : 2));
      cyc();
    end
    wt_we = 1'b0; tbl_len = 3'd3; sink = 4'hF;
    wt_mode = 1'b1;
    for (int i = 0; i < 150; i++) begin
      data_avail = 4'(i * 7 + 2);
      sink       = (i % 11 < 6) ? 4'hF : 4'h5;
      wt_we = (i == 40); wt_addr = 2'd0; wt_data = 2'd0;   // ignored: R8
      cyc();
    end
    wt_we = 1'b0; wt_mode = 1'b0; tbl_len = 3'd4;
    for (int i = 0; i < 30; i++) begin data_avail = 4'hA; cyc(); end
    wt_mode = 1'b1;
    for (int i = 0; i < 120; i++) begin
      data_avail = 4'hF; sink = 4'(i / 3 + 9); cyc();
    end
    wt_mode = 1'b0;
    for (int i = 0; i < 100; i++) begin data_avail = 4'(i); sink = 4'(i * 3); cyc(); end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule